// File: doc/BRIEF.md
# Selectable-Interval Sleep Wake Timer

This block counts edges of a slow clock of about 32 kHz and emits a wake tick at one of four intervals. A 2-bit select input picks the interval. The four intervals are 2^6, 2^9, 2^12 and 2^15 slow-clock cycles, so each one is eight times the one before it. All four come from one free-running 15-bit counter. A tick fires when the low bits of that counter that belong to the chosen interval return to zero. The tick is a single-cycle pulse.

A sticky pending flag goes with the tick and is meant for an interrupt controller. The flag is a two-state machine.
- **PND_IDLE**: the flag is clear.
- **PND_SET**: the flag is set.

It has three transitions.
- **arm**: PND_IDLE to PND_SET, taken on a tick.
- **ack**: PND_SET to PND_IDLE, taken on a clear that does not coincide with a tick.
- **hold**: PND_SET stays in PND_SET when a tick and a clear arrive together.

In any other case the flag keeps its state.

The slow clock reaches this block already chosen, either from the internal low-speed oscillator or from an external crystal. The block that picks between them, the oscillator and the power manager that reacts to the tick are all outside this block.

Top module: `wake_timer`

## Requirements
- R1: An active-low reset clears the counter, the tick and the pending flag at once. Both outputs read 0 while reset is held.
- R2: The select codes map to intervals in ascending order: code 0 gives 64 cycles, code 1 gives 512, code 2 gives 4096 and code 3 gives 32768. With the select held, the first tick after reset appears in the cycle after rising edge number 2^n following reset release, and later ticks follow every 2^n edges.
- R3: A tick is high for exactly one slow-clock cycle.
- R4: Changing the select does not reset the counter. The next tick comes when the count reaches the next multiple of the newly selected interval.
- R5: When a tick is high at a clock edge, the pending flag is high in the following cycle (arm).
- R6: Once set, the pending flag stays high until a clear is applied.
- R7: A clear applied while the flag is set, with no tick in that cycle, makes the flag low in the following cycle (ack).
- R8: When a tick and a clear are high in the same cycle, the flag is high in the following cycle (hold).
- R9: A clear while the flag is low and no tick is present has no effect, and the flag stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow sleep clock, about 32 kHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_sel | input | 2 | Interval select, 0 to 3 for 2^6 to 2^15 cycles |
| tick_clr | input | 1 | Clears the pending flag |
| wake_tick | output | 1 | One-cycle wake pulse |
| wake_pend | output | 1 | Sticky pending flag |

## Verification
A tick that sets the flag and a clear that drops it can land on the same edge. The bench provokes this on purpose. It watches its own model of the counter and raises the clear exactly in a cycle where a tick is high. It then expects the flag to read high in the next cycle. A separate run applies the clear away from any tick and expects the flag to fall. Together these two runs show the tick has priority without hiding the ordinary clear.

// File: rtl/wt_pkg.sv
package wt_pkg;

    typedef enum logic [0:0] {
        PND_IDLE = 1'b0,
        PND_SET  = 1'b1
    } pend_state_e;

    // number of low counter bits that must wrap for a given select code
    function automatic int tap_len(input int base, input int step, input int code);
        return base + step * code;
    endfunction

endpackage

// File: rtl/wt_prescaler.sv
module wt_prescaler #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt
);

    always_comb begin
        cnt_nxt = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
        end
    end

    // R4
    cnt_free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/wt_tap_select.sv
module wt_tap_select #(
    parameter int BASE_LOG2 = 6,
    parameter int STEP_LOG2 = 3,
    parameter int SEL_W     = 2,
    parameter int CNT_W     = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic [CNT_W-1:0] cnt_nxt,
    output logic [CNT_W-1:0] mask_o,
    output logic             tick_q
);

    localparam int NUM_CODES = 1 << SEL_W;

    logic [CNT_W-1:0] mask_tbl [NUM_CODES];

    for (genvar k = 0; k < NUM_CODES; k++) begin : g_tap
        localparam int LEN = wt_pkg::tap_len(BASE_LOG2, STEP_LOG2, k);
        assign mask_tbl[k] = CNT_W'((64'd1 << LEN) - 64'd1);
    end

    assign mask_o = mask_tbl[sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= ((cnt_nxt & mask_o) == '0);
        end
    end

    // R3
    tick_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q);

endmodule

// File: rtl/wt_pending_fsm.sv
module wt_pending_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic clr_i,
    output logic pend_o
);

    import wt_pkg::*;

    pend_state_e state_q;
    pend_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PND_IDLE: if (tick_i) state_d = PND_SET;            // arm
            PND_SET:  if (clr_i && !tick_i) state_d = PND_IDLE; // ack; else hold
            default:  state_d = PND_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PND_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        pend_o = (state_q == PND_SET);
    end

    // R5
    arm_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> pend_o);

    // R6
    hold_without_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> pend_o);

    // R7
    ack_on_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && clr_i && !tick_i) |=> !pend_o);

    // R9
    idle_clr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && !tick_i) |=> !pend_o);

endmodule

// File: rtl/wake_timer.sv
module wake_timer #(
    parameter int BASE_LOG2 = 6,
    parameter int STEP_LOG2 = 3,
    parameter int SEL_W     = 2
) (
    input  logic             clk_slow,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] period_sel,
    input  logic             tick_clr,
    output logic             wake_tick,
    output logic             wake_pend
);

    localparam int NUM_CODES = 1 << SEL_W;
    localparam int CNT_W     = BASE_LOG2 + STEP_LOG2 * (NUM_CODES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] tap_mask;

    wt_prescaler #(.CNT_W(CNT_W)) u_prescaler (
        .clk     (clk_slow),
        .rst_n   (rst_n),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    wt_tap_select #(
        .BASE_LOG2 (BASE_LOG2),
        .STEP_LOG2 (STEP_LOG2),
        .SEL_W     (SEL_W),
        .CNT_W     (CNT_W)
    ) u_tap (
        .clk     (clk_slow),
        .rst_n   (rst_n),
        .sel     (period_sel),
        .cnt_nxt (cnt_nxt),
        .mask_o  (tap_mask),
        .tick_q  (wake_tick)
    );

    wt_pending_fsm u_pend (
        .clk    (clk_slow),
        .rst_n  (rst_n),
        .tick_i (wake_tick),
        .clr_i  (tick_clr),
        .pend_o (wake_pend)
    );

    // R2
    tick_on_wrap_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
        wake_tick |-> ((cnt_q & $past(tap_mask)) == '0));

    // R8
    tick_beats_clr_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (wake_tick && tick_clr) |=> wake_pend);

endmodule

// File: tb/wake_timer_bench.sv
`timescale 1ns/1ps
module wake_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       clr = 1'b0;
    logic       tick;
    logic       pend;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int  mcnt = 0;
    bit  etick = 0;
    bit  epend = 0;
    int  nticks = 0;
    string tag = "R2";

    always #2.5 clk = ~clk;

    wake_timer u_wake_timer (
        .clk_slow   (clk),
        .rst_n      (rst_n),
        .period_sel (sel),
        .tick_clr   (clr),
        .wake_tick  (tick),
        .wake_pend  (pend)
    );

    function automatic int period_of(input logic [1:0] s);
        return 1 << (6 + 3 * int'(s));
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        bit np;
        @(posedge clk);
        np = etick ? 1'b1 : (clr ? 1'b0 : epend);
        mcnt = (mcnt + 1) % 32768;
        etick = ((mcnt % period_of(sel)) == 0);
        epend = np;
        if (etick) nticks++;
        @(negedge clk);
        check(tick == etick, tag, "wake_tick", int'(tick), int'(etick));
        check(pend == epend, tag, "wake_pend", int'(pend), int'(epend));
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        // R1: outputs cleared while reset is held
        check(tick == 1'b0, "R1", "wake_tick in reset", int'(tick), 0);
        check(pend == 1'b0, "R1", "wake_pend in reset", int'(pend), 0);
        mcnt = 0; etick = 0; epend = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_model_tick();
        for (int i = 0; i < 40000; i++) begin
            if (etick) break;
            step();
        end
    endtask

    initial begin
        #1;
        check(tick == 1'b0, "R1", "wake_tick at start", int'(tick), 0);
        check(pend == 1'b0, "R1", "wake_pend at start", int'(pend), 0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 / R3 / R5 / R6: code 0, first tick after 64 edges
        tag = "R2"; sel = 2'd0; nticks = 0;
        run(300);
        check(nticks == 4, "R2", "tick count code0 300cyc", nticks, 4);

        // R7: clear away from a tick
        tag = "R7";
        run(10);
        clr = 1'b1; step(); clr = 1'b0;
        check(pend == 1'b0, "R7", "pend after ack", int'(pend), 0);

        // R9: clear while idle
        tag = "R9";
        clr = 1'b1; run(3); clr = 1'b0;
        check(pend == 1'b0, "R9", "pend after idle clr", int'(pend), 0);

        // R8: clear in the same cycle as a tick
        tag = "R8";
        wait_model_tick();
        clr = 1'b1; step(); clr = 1'b0;
        check(pend == 1'b1, "R8", "pend after tick+clr", int'(pend), 1);
        clr = 1'b1; step(); clr = 1'b0;
        check(pend == 1'b0, "R7", "pend after later ack", int'(pend), 0);

        // R2: codes 1 and 2 from a fresh reset
        do_reset();
        tag = "R2"; sel = 2'd1; nticks = 0;
        run(1100);
        check(nticks == 2, "R2", "tick count code1", nticks, 2);
        do_reset();
        sel = 2'd2; nticks = 0;
        run(8200);
        check(nticks == 2, "R2", "tick count code2", nticks, 2);

        // R4: change select mid-count, counter keeps running
        tag = "R4";
        run(37);
        sel = 2'd0; run(200);
        sel = 2'd3; run(500);
        sel = 2'd1; run(1500);

        // R1: reset mid-run, then R2 code 3 over two periods
        do_reset();
        tag = "R2"; sel = 2'd3; nticks = 0;
        run(65540);
        check(nticks == 2, "R2", "tick count code3", nticks, 2);
        tag = "R3";
        run(64);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule